// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer driven through a small bank of four 32-bit registers. A prescaler divides the reference clock down to a slow tick, normally 1 ms, and a tick counter measures elapsed ticks against a programmed limit. When the counter reaches the limit, the block latches an expiry flag. If the reset output is enabled, it also pulls an active-low system reset request low.

Software arms the timer in two steps. It first writes the limit, then writes a control word. The control word carries four enable bits and an 18-bit divide count; the divide count is the reference frequency divided by 1000. Software then restarts the measurement by writing any value to the kick register. Writing zero to the control word stops the timer completely and releases the reset request.

The register port is synchronous. It takes a write strobe, a word index and 32-bit data. Reads are combinational from the word index.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, word 0 and word 2 read zero, `expired` is 0 and `rst_req_n` is 1.
- R2: Word index 0 (byte offset 0x0) holds the control word and reads back only bits 25, 24, 21, 18 and 17:0, with all other bits zero. Word index 2 (offset 0x8) holds the 32-bit limit and reads back in full. Words 1 (0x4) and 3 (0xC) always read zero, and a write to word 1 changes nothing.
- R3: With control bits 25, 24 and 18 set and divide count D ≥ 1, the counter advances once every D clocks. `expired` therefore rises exactly L·D clock edges after the control write, for a limit L ≥ 1.
- R4: If any one of control bits 25 (prescaler enable), 24 (count clock enable) or 18 (watchdog enable) is clear, the timer never expires.
- R5: When the timer expires, `rst_req_n` goes low on the same edge as `expired` if control bit 21 is set. If bit 21 is clear, `rst_req_n` stays high.
- R6: A write of any data to word 3 clears the tick counter, the prescaler phase and `expired`. This releases `rst_req_n`, and a full L·D clock timeout is measured again from that write.
- R7: A write to word 0 or word 2 restarts the measurement and clears `expired`. Writing zero to word 0 releases `rst_req_n` and stops all counting.
- R8: Once set, `expired` and a low `rst_req_n` hold until a kick or a write to word 0 or 2.
- R9: A limit of 0 expires on the first tick. A divide count of 0 behaves as a divide count of 1.
- R10: A divide count of 24000, the value for a 24 MHz reference, gives a tick every 24000 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word index (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at `addr` |
| expired | output | 1 | Sticky timeout flag |
| rst_req_n | output | 1 | Active-low system reset request |

## Verification
The bench builds the block with its default parameters: a 2-bit word index, 32-bit data, an 18-bit divide field and a 32-bit limit. It programs small divide counts (0 to 3) and small limits (0 to 7), so the exact expiry edge, kicks placed just before expiry, and the degenerate zero settings all fall within a few dozen cycles. A single run with divide count 24000 and a limit of 2 then confirms the 1 ms tick at full scale in 48000 cycles.

// File: rtl/tick_watchdog_pkg.sv
package tick_watchdog_pkg;

  localparam int CW_DIV_W       = 18;
  localparam int CW_PRE_EN_BIT  = 25;
  localparam int CW_CLK_EN_BIT  = 24;
  localparam int CW_RST_OUT_BIT = 21;
  localparam int CW_WD_EN_BIT   = 18;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_SPARE = 2'd1,
    SEL_LIMIT = 2'd2,
    SEL_KICK  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic                pre_en;
    logic                clk_en;
    logic                rst_out_en;
    logic                wd_en;
    logic [CW_DIV_W-1:0] div;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.pre_en     = w[CW_PRE_EN_BIT];
    c.clk_en     = w[CW_CLK_EN_BIT];
    c.rst_out_en = w[CW_RST_OUT_BIT];
    c.wd_en      = w[CW_WD_EN_BIT];
    c.div        = w[CW_DIV_W-1:0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    logic [31:0] w;
    w                 = '0;
    w[CW_PRE_EN_BIT]  = c.pre_en;
    w[CW_CLK_EN_BIT]  = c.clk_en;
    w[CW_RST_OUT_BIT] = c.rst_out_en;
    w[CW_WD_EN_BIT]   = c.wd_en;
    w[CW_DIV_W-1:0]   = c.div;
    return w;
  endfunction

  // Last phase of a prescale period; a divide of 0 wraps every cycle.
  function automatic logic prescale_wrap(input logic [CW_DIV_W-1:0] phase,
                                         input logic [CW_DIV_W-1:0] div);
    return ({1'b0, phase} + 1'b1) >= {1'b0, div};
  endfunction

endpackage

// File: rtl/twd_regs.sv
module twd_regs
  import tick_watchdog_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int TC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output logic [TC_W-1:0]   limit_q,
  output logic              kick_wr,
  output logic              cfg_wr,
  output logic [DATA_W-1:0] rdata
);

  reg_sel_e sel;
  logic     ctrl_wr;
  logic     limit_wr;

  assign sel      = reg_sel_e'(addr[1:0]);
  assign ctrl_wr  = wr_en && (sel == SEL_CTRL);
  assign limit_wr = wr_en && (sel == SEL_LIMIT);
  assign kick_wr  = wr_en && (sel == SEL_KICK);
  assign cfg_wr   = ctrl_wr || limit_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      limit_q <= '0;
    end else begin
      if (ctrl_wr)  ctrl_q  <= ctrl_unpack(wdata[31:0]);
      if (limit_wr) limit_q <= wdata[TC_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_CTRL:  rdata[31:0]     = ctrl_pack(ctrl_q);
      SEL_LIMIT: rdata[TC_W-1:0] = limit_q;
      default:   rdata           = '0;
    endcase
  end

endmodule

// File: rtl/twd_prescaler.sv
module twd_prescaler
  import tick_watchdog_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                restart,
  input  logic [CW_DIV_W-1:0] div,
  output logic                tick
);

  logic [CW_DIV_W-1:0] phase_q;

  assign tick = run && !restart && prescale_wrap(phase_q, div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (restart)  phase_q <= '0;
    else if (tick)     phase_q <= '0;
    else if (run)      phase_q <= phase_q + 1'b1;
  end

endmodule

// File: rtl/twd_counter.sv
module twd_counter #(
  parameter int TC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            restart,
  input  logic [TC_W-1:0] limit,
  output logic [TC_W-1:0] count_q,
  output logic            expired_q,
  output logic            expire_evt
);

  function automatic logic limit_hit(input logic [TC_W-1:0] cnt,
                                     input logic [TC_W-1:0] lim);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, lim};
  endfunction

  assign expire_evt = tick && !expired_q && limit_hit(count_q, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      expired_q <= 1'b0;
    end else if (restart) begin
      count_q   <= '0;
      expired_q <= 1'b0;
    end else if (expire_evt) begin
      count_q   <= limit;
      expired_q <= 1'b1;
    end else if (tick && !expired_q) begin
      count_q   <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import tick_watchdog_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int TC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              expired,
  output logic              rst_req_n
);

  ctrl_t           ctrl_q;
  logic [TC_W-1:0] limit_q;
  logic [TC_W-1:0] count_q;
  logic            kick_wr;
  logic            cfg_wr;
  logic            restart;
  logic            run;
  logic            tick;
  logic            expire_evt;

  twd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TC_W(TC_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .ctrl_q  (ctrl_q),
    .limit_q (limit_q),
    .kick_wr (kick_wr),
    .cfg_wr  (cfg_wr),
    .rdata   (rdata)
  );

  assign restart = kick_wr || cfg_wr;
  assign run     = ctrl_q.pre_en && ctrl_q.clk_en && ctrl_q.wd_en;

  twd_prescaler pre_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .div     (ctrl_q.div),
    .tick    (tick)
  );

  twd_counter #(.TC_W(TC_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .restart    (restart),
    .limit      (limit_q),
    .count_q    (count_q),
    .expired_q  (expired),
    .expire_evt (expire_evt)
  );

  assign rst_req_n = !(expired && ctrl_q.rst_out_en);

endmodule

// File: rtl/tick_watchdog_chk.sv
module tick_watchdog_chk #(
  parameter int TC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            kick_wr,
  input logic            cfg_wr,
  input logic            run,
  input logic            tick,
  input logic            expire_evt,
  input logic            rst_out_en,
  input logic            expired,
  input logic            rst_req_n,
  input logic [TC_W-1:0] count_q,
  input logic [TC_W-1:0] limit_q
);

  AST_TICK_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run); // R4

  AST_COUNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q <= limit_q) || (count_q == '0)); // R3

  AST_EXPIRY_DRIVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && rst_out_en && !cfg_wr) |=> (!rst_req_n && expired)); // R5

  AST_KICK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    kick_wr |=> (!expired && rst_req_n && count_q == '0)); // R6

  AST_CFG_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!expired && count_q == '0)); // R7

  AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !kick_wr && !cfg_wr) |=> expired); // R8

endmodule

bind tick_watchdog tick_watchdog_chk #(.TC_W(TC_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .kick_wr    (kick_wr),
  .cfg_wr     (cfg_wr),
  .run        (run),
  .tick       (tick),
  .expire_evt (expire_evt),
  .rst_out_en (ctrl_q.rst_out_en),
  .expired    (expired),
  .rst_req_n  (rst_req_n),
  .count_q    (count_q),
  .limit_q    (limit_q)
);

// File: tb/tick_watchdog_tb_top.sv
module tick_watchdog_tb_top;

  localparam logic [31:0] B_PRE = 32'h1 << 25;
  localparam logic [31:0] B_CLK = 32'h1 << 24;
  localparam logic [31:0] B_RST = 32'h1 << 21;
  localparam logic [31:0] B_WD  = 32'h1 << 18;
  localparam logic [31:0] DIVM  = (32'h1 << 18) - 1;
  localparam logic [31:0] ALL   = B_PRE | B_CLK | B_RST | B_WD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        expired;
  logic        rst_req_n;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  tick_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .expired(expired), .rst_req_n(rst_req_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(req, rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Called right after a write; expiry expected exactly n edges after it.
  task automatic expect_expiry(input string req, input int n, input logic req_low);
    idle(n - 1);
    chk({req, " before"}, {31'b0, expired}, 32'd0);
    idle(1);
    chk({req, " at"}, {31'b0, expired}, 32'd1);
    chk({req, " req"}, {31'b0, rst_req_n}, {31'b0, !req_low});
  endtask

  task automatic arm(input logic [31:0] lim, input logic [31:0] ctrl);
    wr(2'd2, lim);
    wr(2'd0, ctrl);
  endtask

  task automatic t_reset;
    rd("R1 ctrl", 2'd0, 32'd0);
    rd("R1 limit", 2'd2, 32'd0);
    chk("R1 expired", {31'b0, expired}, 32'd0);
    chk("R1 rst_req_n", {31'b0, rst_req_n}, 32'd1);
  endtask

  task automatic t_readback;
    wr(2'd0, 32'hFFFF_FFFF);
    rd("R2 ctrl mask", 2'd0, ALL | DIVM);
    wr(2'd2, 32'hA5C3_0F96);
    rd("R2 limit", 2'd2, 32'hA5C3_0F96);
    wr(2'd1, 32'h1234_5678);
    rd("R2 spare", 2'd1, 32'd0);
    rd("R2 ctrl kept", 2'd0, ALL | DIVM);
    rd("R2 kick", 2'd3, 32'd0);
    wr(2'd0, 32'd0);
  endtask

  task automatic t_period;
    arm(32'd4, B_PRE | B_CLK | B_WD | B_RST | 32'd3);
    expect_expiry("R3 d3 l4", 12, 1'b1);
    arm(32'd7, B_PRE | B_CLK | B_WD | 32'd1);
    expect_expiry("R3 d1 l7", 7, 1'b0);
  endtask

  task automatic t_enables;
    logic [31:0] bits[3];
    bits[0] = B_PRE; bits[1] = B_CLK; bits[2] = B_WD;
    for (int k = 0; k < 3; k++) begin
      arm(32'd2, (ALL & ~bits[k]) | 32'd2);
      idle(40);
      chk("R4 no expiry", {31'b0, expired}, 32'd0);
      chk("R4 no request", {31'b0, rst_req_n}, 32'd1);
    end
  endtask

  task automatic t_rst_out;
    arm(32'd3, B_PRE | B_CLK | B_WD | 32'd2);
    expect_expiry("R5 no rst enable", 6, 1'b0);
    arm(32'd3, ALL | 32'd2);
    expect_expiry("R5 rst enable", 6, 1'b1);
  endtask

  task automatic t_kick_sticky;
    arm(32'd5, ALL | 32'd2);
    idle(7);
    wr(2'd3, 32'hDEAD_BEEF);
    expect_expiry("R6 after kick", 10, 1'b1);
    idle(50);
    chk("R8 sticky expired", {31'b0, expired}, 32'd1);
    chk("R8 sticky request", {31'b0, rst_req_n}, 32'd0);
    wr(2'd3, 32'd0);
    chk("R6 kick clears", {31'b0, expired}, 32'd0);
    chk("R6 kick releases", {31'b0, rst_req_n}, 32'd1);
    expect_expiry("R6 rerun", 10, 1'b1);
  endtask

  task automatic t_rewrite;
    arm(32'd4, ALL | 32'd2);
    idle(6);
    wr(2'd2, 32'd4);
    expect_expiry("R7 limit rewrite", 8, 1'b1);
    wr(2'd0, 32'd0);
    chk("R7 disable clears", {31'b0, expired}, 32'd0);
    chk("R7 disable releases", {31'b0, rst_req_n}, 32'd1);
    idle(40);
    chk("R7 stays idle", {31'b0, expired}, 32'd0);
  endtask

  task automatic t_zero;
    arm(32'd0, ALL | 32'd3);
    expect_expiry("R9 limit zero", 3, 1'b1);
    arm(32'd5, ALL | 32'd0);
    expect_expiry("R9 divide zero", 5, 1'b1);
  endtask

  task automatic t_full_scale;
    arm(32'd2, ALL | 32'd24000);
    expect_expiry("R10 24000", 48000, 1'b1);
    wr(2'd0, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_readback();
    t_period();
    t_enables();
    t_rst_out();
    t_kick_sticky();
    t_rewrite();
    t_zero();
    t_full_scale();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule